// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Latched Error Status

This block turns a single asynchronous serial line into bytes. A frame consists of a low start bit, eight data bits with the least significant bit first, an optional parity bit and one stop bit. The block samples the line on a 16x oversampling tick that the surrounding logic supplies. The incoming line passes through a two-stage synchronizer. The block confirms the start bit at its midpoint, then samples every later bit at its centre.

When a frame completes, the byte is written to a holding register and the ready flag is raised. Three error flags are raised in that same cycle when they apply: overrun, parity mismatch and bad stop bit. The error flags are latched. Reading the byte does not clear them, and neither does a later good frame. Only the clear-status strobe clears them. The ready flag is cleared by the read strobe.

The framing state machine has five states:
- `ST_IDLE`: waits for a low line on a tick, then moves to `ST_START`.
- `ST_START`: counts to the middle of the start bit. A high line there is a glitch and returns the machine to `ST_IDLE`. A low line moves it to `ST_DATA` and latches the parity mode.
- `ST_DATA`: samples eight bits at their centres. It then moves to `ST_PARITY`, or straight to `ST_STOP` when parity is off.
- `ST_PARITY`: samples the parity bit and moves to `ST_STOP`.
- `ST_STOP`: samples the stop bit, emits the completion strobe and returns to `ST_IDLE`.

Top module: `rx_sticky_uart`

## Requirements
- R1: An active-low `rst_n` forces the receiver idle and drives all of `status` to 0.
- R2: A frame is start (0), D0..D7 least significant first, the optional parity bit, then stop (1). At completion the byte appears on `rx_data` and `status[0]` (ready) is set.
- R3: A pulse on `rd_strobe` clears `status[0]`. If a read coincides with a completion, ready stays set and no overrun is recorded.
- R4: If a frame completes while ready is set and no read occurs in that cycle, `status[1]` (overrun) is set. The new byte replaces the held one, and ready stays set.
- R5: `par_mode` selects the parity rule and is latched when the start bit is confirmed. The codes are 0 = even, 1 = odd, 2 = parity bit must be 0, 3 = parity bit must be 1, and 4..7 = no parity. With no parity the frame carries no parity bit and no parity error is ever raised.
- R6: A parity mismatch sets `status[2]` in the same cycle that ready is set.
- R7: A stop bit sampled as 0 sets `status[3]` in the same cycle that ready is set.
- R8: Once set, `status[3:1]` stay set through later good frames and reads, until `clr_status` is pulsed.
- R9: If `clr_status` coincides with a new error event, the event wins and its flag stays set.
- R10: If the line is high again at the middle of the start bit, the receiver returns to idle without producing a byte.
- R11: Bit timing advances only on `tick16`: 16 ticks make one bit, and each bit is sampled at its centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| par_mode | input | 3 | Parity rule selection |
| rd_strobe | input | 1 | Read of the holding register |
| clr_status | input | 1 | Clears the latched error flags |
| rx_data | output | 8 | Holding register |
| status | output | 4 | {framing, parity, overrun, ready} |

## Verification
The bench holds `clr_status` high across an entire bad frame and releases it only once ready appears. A design that let the clear win would show the flags empty afterwards. A good frame sent after a parity error must leave that error visible; a design that cleared the flags on completion or on a read would lose it. A completion while ready is set must raise overrun and expose the new byte; a design that kept the old byte or dropped ready would fail there. A short low pulse on the line must produce nothing, and the receiver must then still take the next frame cleanly. A run at half the tick rate must still recover the byte, which catches counting on clocks instead of ticks.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    // Parity rule codes carried on par_mode
    localparam logic [2:0] PM_EVEN = 3'd0;
    localparam logic [2:0] PM_ODD  = 3'd1;
    localparam logic [2:0] PM_ZERO = 3'd2;
    localparam logic [2:0] PM_ONE  = 3'd3;

    // Codes 4..7 mean the frame carries no parity bit
    function automatic logic parity_on(input logic [2:0] mode);
        return !mode[2];
    endfunction

    // Value the parity bit must carry, given the XOR of the data bits
    function automatic logic parity_want(input logic [2:0] mode, input logic data_xor);
        logic r;
        unique case (mode)
            PM_EVEN: r = data_xor;
            PM_ODD:  r = ~data_xor;
            PM_ZERO: r = 1'b0;
            PM_ONE:  r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rxs_framer.sv
module rxs_framer
    import rxs_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx,
    input  logic [2:0]           par_mode,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr,
    output logic                 ferr
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    rx_state_t              st, st_n;
    logic [CNT_W-1:0]       cnt, cnt_n;
    logic [IDX_W-1:0]       idx, idx_n;
    logic [DATA_BITS-1:0]   sh, sh_n;
    logic [2:0]             mode_q, mode_n;
    logic                   pbit, pbit_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            idx    <= '0;
            sh     <= '0;
            mode_q <= '0;
            pbit   <= 1'b0;
        end else begin
            cnt    <= cnt_n;
            idx    <= idx_n;
            sh     <= sh_n;
            mode_q <= mode_n;
            pbit   <= pbit_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        idx_n  = idx;
        sh_n   = sh;
        mode_n = mode_q;
        pbit_n = pbit;
        done   = 1'b0;
        perr   = 1'b0;
        ferr   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (tick && !rx) begin
                    st_n  = ST_START;
                    cnt_n = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (cnt == MID_CNT) begin
                        if (rx) begin
                            st_n = ST_IDLE;
                        end else begin
                            st_n   = ST_DATA;
                            cnt_n  = '0;
                            idx_n  = '0;
                            mode_n = par_mode;
                        end
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (cnt == LAST_CNT) begin
                        cnt_n = '0;
                        sh_n  = {rx, sh[DATA_BITS-1:1]};
                        if (idx == LAST_IDX) begin
                            st_n = parity_on(mode_q) ? ST_PARITY : ST_STOP;
                        end else begin
                            idx_n = idx + IDX_W'(1);
                        end
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
            end
            ST_PARITY: begin
                if (tick) begin
                    if (cnt == LAST_CNT) begin
                        cnt_n  = '0;
                        pbit_n = rx;
                        st_n   = ST_STOP;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (cnt == LAST_CNT) begin
                        cnt_n = '0;
                        st_n  = ST_IDLE;
                        done  = 1'b1;
                        ferr  = !rx;
                        perr  = parity_on(mode_q) && (pbit != parity_want(mode_q, ^sh));
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign data = sh;
endmodule

// File: rtl/rxs_status.sv
module rxs_status #(
    parameter int DATA_BITS = 8,
    parameter int N_FLAGS   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 perr,
    input  logic                 ferr,
    input  logic                 rd,
    input  logic                 clr,
    output logic [DATA_BITS-1:0] hold,
    output logic                 ready,
    output logic [N_FLAGS-1:0]   flags
);
    logic [N_FLAGS-1:0] event_v;
    logic               ovr_ev;

    assign ovr_ev  = done && ready && !rd;
    assign event_v = {done && ferr, done && perr, ovr_ev};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold  <= '0;
            ready <= 1'b0;
        end else begin
            if (done) begin
                hold  <= data;
                ready <= 1'b1;
            end else if (rd) begin
                ready <= 1'b0;
            end
        end
    end

    // one latched cell per error; a new event outranks the clear
    genvar i;
    generate
        for (i = 0; i < N_FLAGS; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flags[i] <= 1'b0;
                else        flags[i] <= event_v[i] | (flags[i] & ~clr);
            end
        end
    endgenerate
endmodule

// File: rtl/rx_sticky_uart.sv
module rx_sticky_uart #(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 rx_line,
    input  logic [2:0]           par_mode,
    input  logic                 rd_strobe,
    input  logic                 clr_status,
    output logic [DATA_BITS-1:0] rx_data,
    output logic [3:0]           status
);
    localparam int N_FLAGS = 3;

    logic                 rx_s;
    logic                 done_w;
    logic                 perr_w;
    logic                 ferr_w;
    logic [DATA_BITS-1:0] byte_w;
    logic                 ready_w;
    logic [N_FLAGS-1:0]   flags_w;

    rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rx_s)
    );

    rxs_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx       (rx_s),
        .par_mode (par_mode),
        .done     (done_w),
        .data     (byte_w),
        .perr     (perr_w),
        .ferr     (ferr_w)
    );

    rxs_status #(.DATA_BITS(DATA_BITS), .N_FLAGS(N_FLAGS)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done_w),
        .data  (byte_w),
        .perr  (perr_w),
        .ferr  (ferr_w),
        .rd    (rd_strobe),
        .clr   (clr_status),
        .hold  (rx_data),
        .ready (ready_w),
        .flags (flags_w)
    );

    assign status = {flags_w, ready_w};
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe,
    input logic       clr_status,
    input logic [3:0] status,
    input logic       frame_done,
    input logic       frame_ferr
);
    AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> status == 4'b0000); // R1

    AST_READY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(frame_done)); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> !status[0]); // R3

    AST_READ_AND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && frame_done && !status[1] && !clr_status) |=> (status[0] && !status[1])); // R3

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && status[0] && !rd_strobe) |=> (status[1] && status[0])); // R4

    AST_PARITY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> $past(frame_done)); // R6

    AST_FRAMING_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> $past(frame_done)); // R7

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_status) |=> ((status[3:1] & $past(status[3:1])) == $past(status[3:1]))); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !frame_done) |=> status[3:1] == 3'b000); // R8

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_ferr && clr_status) |=> status[3]); // R9
endmodule

bind rx_sticky_uart rxs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .clr_status (clr_status),
    .status     (status),
    .frame_done (done_w),
    .frame_ferr (ferr_w)
);

// File: tb/tb_rx_sticky_uart.sv
module tb_rx_sticky_uart;
    localparam int NV = 11;
    // {mode[2:0], data[7:0], bad_par, bad_stop, rd_after, clr_after, exp_status[3:0]}
    localparam logic [18:0] VECS [NV] = '{
        {3'd0, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
        {3'd1, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
        {3'd2, 8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
        {3'd3, 8'h7E, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
        {3'd4, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
        {3'd0, 8'h12, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0101},
        {3'd0, 8'h34, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0101},
        {3'd1, 8'h56, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1001},
        {3'd7, 8'h9A, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001},
        {3'd0, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0011},
        {3'd4, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1001}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [2:0] par_mode = 3'd0;
    logic       rd_strobe = 1'b0;
    logic       clr_status = 1'b0;
    logic [7:0] rx_data;
    logic [3:0] status;

    int total = 0;
    int fails = 0;
    int tick_every = 1;

    rx_sticky_uart dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .rx_line    (rx_line),
        .par_mode   (par_mode),
        .rd_strobe  (rd_strobe),
        .clr_status (clr_status),
        .rx_data    (rx_data),
        .status     (status)
    );

    always #2 clk = ~clk;

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            if (tick_every <= 1) begin
                tick16 = 1'b1;
            end else begin
                tick16 = (tc == 0);
                tc = (tc + 1) % tick_every;
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rx_line = b;
        repeat (16 * tick_every) @(negedge clk);
    endtask

    task automatic send_frame(input logic [2:0] mode, input logic [7:0] d,
                              input logic bad_par, input logic bad_stop);
        logic p;
        unique case (mode)
            3'd0:    p = ^d;
            3'd1:    p = ~^d;
            3'd2:    p = 1'b0;
            3'd3:    p = 1'b1;
            default: p = 1'b0;
        endcase
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (!mode[2]) send_bit(p ^ bad_par);
        send_bit(!bad_stop);
        rx_line = 1'b1;
        idle(40 * tick_every);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        idle(5);
        chk("R1 status under reset", {4'h0, status}, 8'h00);
        rst_n = 1'b1;
        idle(5);
        chk("R1 status after reset", {4'h0, status}, 8'h00);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [18:0] e;
            string tag;
            e = VECS[v];
            par_mode = e[18:16];
            send_frame(e[18:16], e[15:8], e[7], e[6]);
            if (e[3])      tag = "R7 framing";
            else if (e[2]) tag = "R6 R8 parity";
            else if (e[1]) tag = "R4 overrun";
            else           tag = "R2 R5 ready";
            chk(tag, {4'h0, status}, {4'h0, e[3:0]});
            chk("R2 R4 byte", rx_data, e[15:8]);
            if (e[5]) begin
                pulse_rd();
                chk("R3 read clears ready", {7'h0, status[0]}, 8'h00);
            end
            if (e[4]) begin
                pulse_clr();
                if (e[5]) chk("R3 R8 all cleared", {4'h0, status}, 8'h00);
            end
        end

        // R8: reads alone do not clear a latched flag
        par_mode = 3'd1;
        send_frame(3'd1, 8'h44, 1'b1, 1'b0);
        pulse_rd();
        pulse_rd();
        chk("R8 parity flag survives reads", {4'h0, status}, 8'h04);
        pulse_clr();
        chk("R8 clear empties flags", {4'h0, status}, 8'h00);

        // R10: short low pulse is rejected
        rx_line = 1'b0;
        idle(5);
        rx_line = 1'b1;
        idle(60);
        chk("R10 glitch gives no byte", {4'h0, status}, 8'h00);
        par_mode = 3'd0;
        send_frame(3'd0, 8'h6D, 1'b0, 1'b0);
        chk("R10 next frame status", {4'h0, status}, 8'h01);
        chk("R10 next frame byte", rx_data, 8'h6D);
        pulse_rd();

        // R11: half-rate tick
        tick_every = 2;
        idle(8);
        send_frame(3'd0, 8'h5B, 1'b0, 1'b0);
        chk("R11 slow tick status", {4'h0, status}, 8'h01);
        chk("R11 slow tick byte", rx_data, 8'h5B);
        pulse_rd();
        tick_every = 1;
        idle(8);

        // R9: clear held high through an errored completion
        clr_status = 1'b1;
        fork
            send_frame(3'd0, 8'h21, 1'b1, 1'b1);
            begin
                do @(negedge clk); while (!status[0]);
                clr_status = 1'b0;
            end
        join
        chk("R9 event beats clear", {4'h0, status}, 8'h0D);
        pulse_rd();
        pulse_clr();
        chk("R9 cleared afterwards", {4'h0, status}, 8'h00);

        // R1: reset while flags are set
        send_frame(3'd0, 8'h77, 1'b0, 1'b1);
        rst_n = 1'b0;
        idle(3);
        chk("R1 reset drops flags", {4'h0, status}, 8'h00);
        rst_n = 1'b1;
        idle(3);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule